// File: doc/BRIEF.md
# Cancelling Dual-Rail Pipeline

A chain of clock-sampled pipeline stages that carries dual-rail data tokens forward and cancel requests (anti-tokens) backward. A downstream early-output function that has already formed its result does not need to wait for a late operand. It raises a cancel instead. The chain acknowledges that cancel at once, which is the early validity of the handshake. The cancel then walks upstream through empty stages until it meets the token it was meant for, and the two destroy each other. When no token is met, the cancel leaves at the input side and the source drops its next token.

Each stage is empty, holds one token, or holds one anti-token. Every meeting is settled by a fixed rule, with no arbiter and no mutual-exclusion element. A token and an anti-token that face each other across a stage boundary are both removed. An empty stage that is offered both in the same cycle stays empty, and both offers are consumed.

The dual-rail encoding is per bit: `t` high means a one, `f` high means a zero, both low is the NULL spacer, and both high is illegal. A word counts as a token only when every bit carries exactly one high rail.

Top module: `at_pipe`

## Requirements
- R1: After reset every stage is empty: `out_vld_o`, `up_cancel_o`, `in_ack_o` and `dn_cancel_ack_o` are low, and `out_t_o`/`out_f_o` are all zero, while the inputs are idle.
- R2: An input word is accepted (`in_ack_o` high in that cycle) only when every bit has exactly one of `in_t_i[i]`/`in_f_i[i]` high. A word with any bit at 00 or 11 is never accepted and never reaches the output.
- R3: A token accepted into an empty chain moves one stage per clock and shows `out_vld_o` after `STAGES` rising edges, counting the edge that accepted it. It carries the input rails unchanged. While `out_vld_o` is low both output rails are all zero.
- R4: A token at the output holds its rails stable until it is delivered. Delivery happens in a cycle with `out_vld_o`, `out_rdy_i` and no `dn_cancel_i`, and `out_vld_o` is low in the cycle after that.
- R5: Delivered tokens keep the order in which they were accepted. Cancelling only removes tokens and never reorders them.
- R6: `dn_cancel_i` is acknowledged by `dn_cancel_ack_o` in the same cycle, without waiting for data, when the last stage is empty or holds a token.
- R7: An acknowledged cancel moves one stage upstream per clock through empty stages. In an empty chain it raises `up_cancel_o` for exactly one cycle, after `STAGES` rising edges counting the accepting edge.
- R8: A cancel raised while `out_vld_o` is high destroys the output token. It is acknowledged, the token is not delivered, `out_vld_o` is low in the next cycle, and no cancel comes out at `up_cancel_o`.
- R9: A token and a cancel that meet inside the chain destroy each other. This holds whether they face each other across a boundary or arrive at the same empty stage in the same cycle. Neither reaches an end of the chain.
- R10: A complete input word presented while the first stage holds a cancel is acknowledged and destroyed. `up_cancel_o` stays low in that cycle, and the word never reaches the output.
- R11: Once the chain is drained, tokens delivered equal tokens accepted minus (cancels acknowledged minus cancels emitted at `up_cancel_o`).
- R12: While the last stage holds a cancel, a new `dn_cancel_i` is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_t_i | input | W | Input true rails |
| in_f_i | input | W | Input false rails |
| in_ack_o | output | 1 | Input word consumed (stored or cancelled) this cycle |
| up_cancel_o | output | 1 | Cancel leaving the chain toward the source (source drops its next token) |
| out_t_o | output | W | Output true rails, zero when no token |
| out_f_o | output | W | Output false rails, zero when no token |
| out_vld_o | output | 1 | Last stage holds a token |
| out_rdy_i | input | 1 | Consumer takes the output token |
| dn_cancel_i | input | 1 | Cancel request from the consumer |
| dn_cancel_ack_o | output | 1 | Cancel request accepted this cycle |

## Verification
A stage stuck in the wrong state shows at the ports within about `STAGES` cycles. A lost token appears as a missing delivery. A lost cancel shows up as an extra delivery or a missing `up_cancel_o` pulse. A collision that fails to annihilate leaks either a token to `out_vld_o` or a cancel to `up_cancel_o`. The directed cases place token and cancel so that they meet at the output boundary, between two stages, at one empty stage, and at the input boundary. Each case then watches both ends for two chain lengths. A long pseudo-random run with mixed traffic checks the count balance and the delivery order after draining.

// File: rtl/at_pkg.sv
package at_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'b00,
    ST_TOK   = 2'b01,
    ST_ANTI  = 2'b10
  } at_state_e;
endpackage

// File: rtl/at_dr_complete.sv
module at_dr_complete #(
  parameter int W = 8
) (
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] f_i,
  output logic         complete_o
);
  logic [W-1:0] bit_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // exactly one rail high: 01 or 10
    assign bit_ok[i] = t_i[i] ^ f_i[i];
  end

  assign complete_o = &bit_ok;
endmodule

// File: rtl/at_cell.sv
module at_cell
  import at_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_tok_i,
  input  logic [W-1:0] up_t_i,
  input  logic [W-1:0] up_f_i,
  input  logic         up_col_i,
  input  logic         up_take_i,
  input  logic         dn_anti_i,
  input  logic         dn_col_i,
  input  logic         dn_take_i,
  output logic         tok_take_o,
  output logic         anti_take_o,
  output logic         has_tok_o,
  output logic         has_anti_o,
  output logic [W-1:0] t_o,
  output logic [W-1:0] f_o
);
  at_state_e    state_q, state_d;
  logic [W-1:0] t_q, f_q;
  logic         is_empty;

  assign is_empty    = (state_q == ST_EMPTY);
  assign tok_take_o  = is_empty && up_tok_i && !up_col_i;
  assign anti_take_o = is_empty && dn_anti_i && !dn_col_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_EMPTY: begin
        if (tok_take_o && anti_take_o) state_d = ST_EMPTY;
        else if (tok_take_o)           state_d = ST_TOK;
        else if (anti_take_o)          state_d = ST_ANTI;
      end
      ST_TOK:  if (dn_take_i || dn_col_i) state_d = ST_EMPTY;
      ST_ANTI: if (up_take_i || up_col_i) state_d = ST_EMPTY;
      default: state_d = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_EMPTY;
      t_q     <= '0;
      f_q     <= '0;
    end else begin
      state_q <= state_d;
      if (tok_take_o && !anti_take_o) begin
        t_q <= up_t_i;
        f_q <= up_f_i;
      end
    end
  end

  assign has_tok_o  = (state_q == ST_TOK);
  assign has_anti_o = (state_q == ST_ANTI);
  assign t_o        = has_tok_o ? t_q : '0;
  assign f_o        = has_tok_o ? f_q : '0;

  AST_TOK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    has_tok_o && !dn_take_i && !dn_col_i |=> has_tok_o && $stable(t_o) && $stable(f_o)); // R4
  AST_SAME_STAGE_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_take_o && anti_take_o |=> !has_tok_o && !has_anti_o); // R9
  AST_ANTI_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    has_anti_o && !up_take_i && !up_col_i |=> has_anti_o); // R7
endmodule

// File: rtl/at_pipe.sv
module at_pipe #(
  parameter int STAGES = 4,
  parameter int W      = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_t_i,
  input  logic [W-1:0] in_f_i,
  output logic         in_ack_o,
  output logic         up_cancel_o,
  output logic [W-1:0] out_t_o,
  output logic [W-1:0] out_f_o,
  output logic         out_vld_o,
  input  logic         out_rdy_i,
  input  logic         dn_cancel_i,
  output logic         dn_cancel_ack_o
);
  localparam int LAST = STAGES - 1;

  logic              in_complete;
  // boundary b sits in front of stage b; boundary STAGES is the output edge
  logic [STAGES:0]   tok_off, anti_off, col;
  logic [LAST:0]     tok_take, anti_take, has_tok, has_anti, dn_take, up_take;
  logic [W-1:0]      rail_t [STAGES+1];
  logic [W-1:0]      rail_f [STAGES+1];

  at_dr_complete #(.W(W)) u_in_cd (
    .t_i        (in_t_i),
    .f_i        (in_f_i),
    .complete_o (in_complete)
  );

  assign tok_off  = {has_tok, in_complete};
  assign anti_off = {dn_cancel_i, has_anti};
  assign col      = tok_off & anti_off;   // facing pair across a boundary dies
  assign dn_take  = {out_rdy_i, tok_take[LAST:1]};
  assign up_take  = {anti_take[LAST-1:0], 1'b1};  // source always absorbs a cancel

  assign rail_t[0] = in_t_i;
  assign rail_f[0] = in_f_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    at_cell #(.W(W)) u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .up_tok_i    (tok_off[s]),
      .up_t_i      (rail_t[s]),
      .up_f_i      (rail_f[s]),
      .up_col_i    (col[s]),
      .up_take_i   (up_take[s]),
      .dn_anti_i   (anti_off[s+1]),
      .dn_col_i    (col[s+1]),
      .dn_take_i   (dn_take[s]),
      .tok_take_o  (tok_take[s]),
      .anti_take_o (anti_take[s]),
      .has_tok_o   (has_tok[s]),
      .has_anti_o  (has_anti[s]),
      .t_o         (rail_t[s+1]),
      .f_o         (rail_f[s+1])
    );
  end

  assign in_ack_o        = col[0] | tok_take[0];
  assign up_cancel_o     = has_anti[0] & ~col[0];
  assign out_vld_o       = has_tok[LAST];
  assign out_t_o         = rail_t[STAGES];
  assign out_f_o         = rail_f[STAGES];
  assign dn_cancel_ack_o = col[STAGES] | anti_take[LAST];

  AST_ACK_COMPLETE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o |-> ((in_t_i ^ in_f_i) == {W{1'b1}})); // R2
  AST_OUT_NULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> (out_t_o == '0) && (out_f_o == '0)); // R3
  AST_OUT_DUAL_RAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> ((out_t_o ^ out_f_o) == {W{1'b1}})); // R3
  AST_OUT_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o && dn_cancel_i |=> !out_vld_o); // R8
  AST_CANCEL_ACK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_cancel_ack_o |-> dn_cancel_i); // R6
  AST_IN_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_cancel_o |-> !in_ack_o); // R10
endmodule

// File: tb/at_pipe_tb.sv
module at_pipe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 4;
  localparam int W          = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] in_t = '0, in_f = '0;
  logic         out_rdy = 1'b0, dn_cancel = 1'b0;
  logic         in_ack, up_cancel, out_vld, dn_cancel_ack;
  logic [W-1:0] out_t, out_f;

  at_pipe #(.STAGES(STAGES), .W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_t_i(in_t), .in_f_i(in_f), .in_ack_o(in_ack), .up_cancel_o(up_cancel),
    .out_t_o(out_t), .out_f_o(out_f), .out_vld_o(out_vld), .out_rdy_i(out_rdy),
    .dn_cancel_i(dn_cancel), .dn_cancel_ack_o(dn_cancel_ack)
  );

  int n_chk = 0, n_bad = 0;
  int n_acc, n_del, n_cack, n_upc, last_val, order_bad;
  int del_log [16];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [W-1:0] v);
    in_t = v; in_f = ~v;
  endtask

  task automatic spacer();
    in_t = '0; in_f = '0;
  endtask

  // observe this cycle, then advance to the next falling edge
  task automatic cyc();
    #1;
    if (in_ack) n_acc++;
    if (dn_cancel_ack) n_cack++;
    if (up_cancel) n_upc++;
    if (out_vld && out_rdy && !dn_cancel) begin
      if (n_del < 16) del_log[n_del] = int'(out_t);
      if (int'(out_t) <= last_val) order_bad++;
      last_val = int'(out_t);
      n_del++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic reset_dut();
    spacer(); out_rdy = 0; dn_cancel = 0; rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    n_acc = 0; n_del = 0; n_cack = 0; n_upc = 0; last_val = 0; order_bad = 0;
  endtask

  task automatic t_reset();
    reset_dut();
    #1;
    chk(!out_vld && !up_cancel && !in_ack && !dn_cancel_ack, "R1 flags", int'(out_vld), 0);
    chk(out_t == '0 && out_f == '0, "R1 rails", int'(out_t | out_f), 0);
  endtask

  task automatic t_forward();
    reset_dut();
    put(8'hA5);
    #1 chk(in_ack == 1'b1, "R2 accept", int'(in_ack), 1);
    cyc();
    spacer();
    for (int k = 1; k < STAGES; k++) begin
      #1 chk(!out_vld, "R3 latency early", int'(out_vld), 0);
      cyc();
    end
    #1 chk(out_vld && out_t == 8'hA5 && out_f == 8'h5A, "R3 latency data", int'(out_t), 'hA5);
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk(out_vld && out_t == 8'hA5 && out_f == 8'h5A, "R4 hold", int'(out_t), 'hA5);
    end
    out_rdy = 1;
    cyc();
    out_rdy = 0;
    #1 chk(!out_vld && n_del == 1, "R4 delivered once", n_del, 1);
    chk(out_t == '0 && out_f == '0, "R3 null when empty", int'(out_t | out_f), 0);
  endtask

  task automatic t_invalid();
    reset_dut();
    in_t = 8'hFF; in_f = 8'h01;
    #1 chk(!in_ack, "R2 rail 11 rejected", int'(in_ack), 0);
    cyc();
    in_t = 8'h0F; in_f = 8'h70;
    #1 chk(!in_ack, "R2 rail 00 rejected", int'(in_ack), 0);
    run(2 * STAGES);
    spacer();
    run(2);
    chk(!out_vld && n_acc == 0, "R2 nothing entered", n_acc, 0);
  endtask

  task automatic t_order();
    logic [W-1:0] vals [3];
    int idx;
    bit a;
    vals[0] = 8'h11; vals[1] = 8'h22; vals[2] = 8'h33;
    reset_dut();
    out_rdy = 1;
    idx = 0;
    while (idx < 3) begin
      put(vals[idx]);
      #1 a = in_ack;
      cyc();
      if (a) begin
        idx++;
        spacer();
        cyc();
      end
    end
    run(3 * STAGES);
    out_rdy = 0;
    chk(n_del == 3, "R5 count", n_del, 3);
    for (int i = 0; i < 3; i++)
      chk(del_log[i] == int'(vals[i]), "R5 order", del_log[i], int'(vals[i]));
  endtask

  task automatic t_cancel_travel();
    reset_dut();
    dn_cancel = 1;
    #1 chk(dn_cancel_ack, "R6 early ack", int'(dn_cancel_ack), 1);
    cyc();
    dn_cancel = 0;
    for (int k = 1; k < STAGES; k++) begin
      #1 chk(!up_cancel, "R7 travel early", int'(up_cancel), 0);
      cyc();
    end
    #1 chk(up_cancel, "R7 arrival", int'(up_cancel), 1);
    cyc();
    #1 chk(!up_cancel, "R7 single pulse", int'(up_cancel), 0);
  endtask

  task automatic t_stall();
    reset_dut();
    dn_cancel = 1;
    #1 chk(dn_cancel_ack, "R6 first ack", int'(dn_cancel_ack), 1);
    cyc();
    #1 chk(!dn_cancel_ack, "R12 stall", int'(dn_cancel_ack), 0);
    cyc();
    #1 chk(dn_cancel_ack, "R6 second ack", int'(dn_cancel_ack), 1);
    cyc();
    dn_cancel = 0;
    run(3 * STAGES);
    chk(n_cack == 2 && n_upc == 2, "R7 both exit", n_upc, 2);
  endtask

  task automatic t_collide_out();
    reset_dut();
    put(8'h3C);
    cyc();
    spacer();
    run(STAGES - 1);
    #1 chk(out_vld, "R8 token at output", int'(out_vld), 1);
    dn_cancel = 1;
    #1 chk(dn_cancel_ack, "R8 ack", int'(dn_cancel_ack), 1);
    cyc();
    dn_cancel = 0;
    #1 chk(!out_vld, "R8 token gone", int'(out_vld), 0);
    out_rdy = 1;
    run(3 * STAGES);
    out_rdy = 0;
    chk(n_del == 0 && n_upc == 0, "R8 nothing leaks", n_del + n_upc, 0);
  endtask

  task automatic t_collide_mid(input int gap);
    reset_dut();
    out_rdy = 1;
    put(8'h77);
    if (gap == 0) dn_cancel = 1;
    cyc();
    spacer();
    dn_cancel = 0;
    if (gap == 1) begin
      dn_cancel = 1;
      cyc();
      dn_cancel = 0;
    end
    run(3 * STAGES);
    out_rdy = 0;
    chk(n_acc == 1 && n_cack == 1, "R9 both accepted", n_cack, 1);
    chk(n_del == 0 && n_upc == 0, "R9 annihilated", n_del + n_upc, 0);
  endtask

  task automatic t_collide_in();
    reset_dut();
    out_rdy = 1;
    dn_cancel = 1;
    cyc();
    dn_cancel = 0;
    run(STAGES - 1);
    put(8'h42);
    #1 chk(in_ack && !up_cancel, "R10 input collision", int'(up_cancel), 0);
    cyc();
    spacer();
    run(3 * STAGES);
    out_rdy = 0;
    chk(n_del == 0 && n_upc == 0, "R10 nothing leaks", n_del + n_upc, 0);
  endtask

  task automatic t_conserve();
    logic [15:0] lfsr;
    bit pending, a;
    int next_val, budget;
    reset_dut();
    lfsr = 16'hACE1; pending = 0; next_val = 1; budget = 0;
    while (next_val <= 250 && budget < 6000) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (!pending && lfsr[0]) begin
        pending = 1;
        put(W'(next_val));
      end
      out_rdy = lfsr[3] | lfsr[5];
      dn_cancel = (lfsr[7:6] == 2'b00) && lfsr[9];
      #1 a = in_ack;
      cyc();
      if (a) begin
        pending = 0;
        next_val++;
        spacer();
      end
      budget++;
    end
    spacer(); dn_cancel = 0; out_rdy = 1;
    run(4 * STAGES);
    chk(n_del == n_acc - (n_cack - n_upc), "R11 conservation", n_del, n_acc - (n_cack - n_upc));
    chk(n_del > 0 && n_cack > n_upc, "R11 traffic mixed", n_cack - n_upc, 1);
    chk(order_bad == 0, "R5 random order", order_bad, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_forward();
    t_invalid();
    t_order();
    t_cancel_travel();
    t_stall();
    t_collide_out();
    t_collide_mid(0);
    t_collide_mid(1);
    t_collide_in();
    t_conserve();
    done = 1;
    finish_run();
  end
endmodule